// File: doc/BRIEF.md
# Embedded Processor Interval and Watchdog Timer Group

This block is the group of interval timers that sits next to an embedded processor core. It has no time base of its own. Instead it counts a tick enable and keeps a small free-running count of those ticks. Three timers use that tick:

- **Programmable interval timer.** A down-counter that is loaded from software. It can reload itself automatically when it expires.
- **Fixed interval timer.** Its period is chosen from four powers of two of the tick count.
- **Watchdog.** It has three stages. The first expiry after service only sets a flag. The second raises an interrupt. The third records the configured reset kind and requests that reset.

Software reaches the block through one register port with three registers:

- a countdown register;
- a control register, of which only the upper ten bits are kept;
- a status register, in which writing a 1 clears the bit.

Reads are combinational from the selected address. A write takes effect at the next clock edge. A tick is counted at the same edge. The interrupt outputs are levels: each is a status bit ANDed with its enable bit in the control register. Each reset request is a single-cycle pulse that the chip's reset controller must capture.

Top module: `emb_timer_group`

## Requirements
- R1: After reset, all three registers read zero and every interrupt and reset output is low.
- R2: A write to the control register (address 1) keeps bits 31..22 and stores zero in bits 21..0.
- R3: A write to the status register (address 2) clears each bit among 31..26 that is 1 in the written data, and leaves all other bits unchanged. When bit 31 of the written data is 1, status bit 27 is also cleared, which withdraws a pending interval-timer interrupt.
- R4: A write to the countdown register (address 0) stores the reload value and loads the count. Reading address 0 returns the current count, which drops by one on each tick while the timer runs.
- R5: When a running count at 1 receives a tick, status bit 27 is set. irq_pit equals status bit 27 AND control bit 26.
- R6: At expiry with control bit 22 set, the count restarts from the reload value. With bit 22 clear, the count goes to 0 and stops.
- R7: The interval timer does not run when the written value is 0 or 1, or when control bit 26 is clear. Writing the control register with bit 26 clear stops a running count.
- R8: The fixed interval timer expires every 2^(FIT_SHIFT0 + k*FIT_STEP) ticks, where k is control bits 25..24. Each expiry sets status bit 26. irq_fit equals status bit 26 AND control bit 23.
- R9: The watchdog expires every 2^(WD_SHIFT0 + k*WD_STEP) ticks, where k is control bits 31..30. The action depends on the status bits:
  - bits 31 and 30 both clear: the expiry sets bit 31;
  - only bit 31 set: the expiry sets bit 30.
  irq_wdog equals status bit 30 AND control bit 27.
- R10: At a watchdog expiry with status bit 30 already set, control bits 29..28 are copied into status bits 29..28. On the next cycle exactly one of the following happens, as a single-cycle pulse or nothing:
  - 0: no reset request;
  - 1: rst_core;
  - 2: rst_chip;
  - 3: rst_sys.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base tick enable, one count per cycle when high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 countdown, 1 control, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (zero for address 3) |
| irq_pit | output | 1 | Interval timer interrupt |
| irq_fit | output | 1 | Fixed interval timer interrupt |
| irq_wdog | output | 1 | Watchdog interrupt |
| rst_core | output | 1 | Core reset request pulse |
| rst_chip | output | 1 | Chip reset request pulse |
| rst_sys | output | 1 | System reset request pulse |

## Verification
A corrupted tick count shows up as a fixed-timer or watchdog status bit that appears a tick early or late. Because the bench counts the exact tick on which each status bit should first appear, such an error is caught within one period. A wrong watchdog stage shows up on the status register, and on the reset pulse outputs, at the very next expiry. A reset of the wrong kind, or a reset that lasts two cycles, is visible on the cycle after that expiry. A countdown that reloads wrongly or fails to stop is read back at address 0 a few ticks after the expiry.

// File: rtl/emb_timer_group.sv
module emb_timer_group #(
  parameter int FIT_SHIFT0 = 9,
  parameter int FIT_STEP   = 4,
  parameter int WD_SHIFT0  = 17,
  parameter int WD_STEP    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_pit,
  output logic        irq_fit,
  output logic        irq_wdog,
  output logic        rst_core,
  output logic        rst_chip,
  output logic        rst_sys
);
  localparam int TBW = WD_SHIFT0 + 3 * WD_STEP;
  localparam logic [31:0] CTRL_KEEP = 32'hFFC0_0000;
  localparam logic [31:0] STAT_CLR  = 32'hFC00_0000;

  logic [31:0]    tcr, tsr, pit_cnt, pit_rld;
  logic           pit_run;
  logic [TBW-1:0] tb_cnt, fit_mask, wd_mask;
  logic           wr_pit, wr_tcr, wr_tsr;
  logic           pit_exp, fit_hit, wd_hit, wd_final;
  logic [31:0]    tsr_set, tsr_clr, tsr_nxt;

  assign wr_pit = reg_we && reg_addr == 2'd0;
  assign wr_tcr = reg_we && reg_addr == 2'd1;
  assign wr_tsr = reg_we && reg_addr == 2'd2;

  always_comb begin
    int fsh, wsh;
    fsh = FIT_SHIFT0 + int'(tcr[25:24]) * FIT_STEP;
    wsh = WD_SHIFT0 + int'(tcr[31:30]) * WD_STEP;
    fit_mask = TBW'((64'd1 << fsh) - 64'd1);
    wd_mask  = TBW'((64'd1 << wsh) - 64'd1);
  end

  assign fit_hit  = tick && ((tb_cnt & fit_mask) == fit_mask);
  assign wd_hit   = tick && ((tb_cnt & wd_mask) == wd_mask);
  assign wd_final = wd_hit && tsr[30];
  assign pit_exp  = tick && pit_run && pit_cnt == 32'd1 && !wr_pit;

  always_comb begin
    tsr_set = '0;
    tsr_set[27] = pit_exp;
    tsr_set[26] = fit_hit;
    if (wd_hit && !tsr[30]) begin
      if (tsr[31]) tsr_set[30] = 1'b1;
      else         tsr_set[31] = 1'b1;
    end
    tsr_clr = '0;
    if (wr_tsr) begin
      tsr_clr = reg_wdata & STAT_CLR;
      tsr_clr[27] = reg_wdata[27] | reg_wdata[31];
    end
    tsr_nxt = (tsr & ~tsr_clr) | tsr_set;
    if (wd_final) tsr_nxt[29:28] = tcr[29:28];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_cnt   <= '0;
      tcr      <= '0;
      tsr      <= '0;
      rst_core <= 1'b0;
      rst_chip <= 1'b0;
      rst_sys  <= 1'b0;
    end else begin
      if (tick) tb_cnt <= tb_cnt + 1'b1;
      if (wr_tcr) tcr <= reg_wdata & CTRL_KEEP;
      tsr      <= tsr_nxt;
      rst_core <= wd_final && tcr[29:28] == 2'd1;
      rst_chip <= wd_final && tcr[29:28] == 2'd2;
      rst_sys  <= wd_final && tcr[29:28] == 2'd3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pit_cnt <= '0;
      pit_rld <= '0;
      pit_run <= 1'b0;
    end else begin
      if (wr_pit) begin
        pit_rld <= reg_wdata;
        pit_cnt <= reg_wdata;
        pit_run <= reg_wdata > 32'd1 && tcr[26];
      end else if (tick && pit_run) begin
        if (pit_cnt == 32'd1) begin
          if (tcr[22]) pit_cnt <= pit_rld;
          else begin
            pit_cnt <= '0;
            pit_run <= 1'b0;
          end
        end else begin
          pit_cnt <= pit_cnt - 1'b1;
        end
      end
      if (wr_tcr && !reg_wdata[26]) pit_run <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = pit_cnt;
      2'd1:    reg_rdata = tcr;
      2'd2:    reg_rdata = tsr;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_pit  = tsr[27] & tcr[26];
  assign irq_fit  = tsr[26] & tcr[23];
  assign irq_wdog = tsr[30] & tcr[27];
endmodule

// File: rtl/emb_timer_group_chk.sv
module emb_timer_group_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] tcr,
  input logic [31:0] tsr,
  input logic [31:0] pit_cnt,
  input logic        pit_run,
  input logic        rst_core,
  input logic        rst_chip,
  input logic        rst_sys
);
  logic any_rst;
  assign any_rst = rst_core | rst_chip | rst_sys;

  AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_core, rst_chip, rst_sys})); // R10
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    any_rst |=> !any_rst); // R10
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_rst) |-> $past(tsr[30])); // R10
  AST_CTRL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1) |=> tcr == ($past(reg_wdata) & 32'hFFC0_0000)); // R2
  AST_PIT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pit_run && pit_cnt > 32'd1 && !(reg_we && reg_addr == 2'd0))
      |=> pit_cnt == $past(pit_cnt) - 32'd1); // R4
  AST_TSR_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd2 && reg_wdata[31] && !(tick && pit_run && pit_cnt == 32'd1))
      |=> !tsr[27]); // R3
endmodule

bind emb_timer_group emb_timer_group_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tcr(tcr), .tsr(tsr), .pit_cnt(pit_cnt), .pit_run(pit_run),
  .rst_core(rst_core), .rst_chip(rst_chip), .rst_sys(rst_sys)
);

// File: tb/sim_emb_timer_group.sv
`timescale 1ns/1ps
module sim_emb_timer_group;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_pit, irq_fit, irq_wdog, rst_core, rst_chip, rst_sys;

  always #2.5 clk = ~clk;

  emb_timer_group #(.FIT_SHIFT0(2), .FIT_STEP(1), .WD_SHIFT0(3), .WD_STEP(1)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pit(irq_pit), .irq_fit(irq_fit),
    .irq_wdog(irq_wdog), .rst_core(rst_core), .rst_chip(rst_chip), .rst_sys(rst_sys));

  typedef struct { int sel; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int tests = 0, failed = 0;
  bit done = 0;

  // monitor: pops expected items and compares with the design's ports
  initial forever begin
    item_t it;
    logic [31:0] act;
    wait (sb.size() != 0);
    it = sb.pop_front();
    act = (it.sel == 3) ? {26'd0, irq_pit, irq_fit, irq_wdog, rst_core, rst_chip, rst_sys}
                        : reg_rdata;
    tests++;
    if (act !== it.exp) begin
      failed++;
      $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
    end
  end

  task automatic expect_val(input int sel, input logic [31:0] exp, input string tag);
    item_t it;
    if (sel < 3) reg_addr = 2'(sel);
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    #1;
  endtask

  task automatic cyc(input bit tk);
    tick = tk;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failed++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_val(0, 32'h0, "R1 count");
    expect_val(1, 32'h0, "R1 control");
    expect_val(2, 32'h0, "R1 status");
    expect_val(3, 32'h0, "R1 outputs");

    wr(2'd1, 32'hFFFF_FFFF);
    expect_val(1, 32'hFFC0_0000, "R2 mask");
    wr(2'd1, 32'h0080_0000);
    expect_val(1, 32'h0080_0000, "R2 rewrite");

    // fixed timer: period 4 then 8 (tb 0..7)
    ticks(3);
    expect_val(2, 32'h0, "R8 early");
    ticks(1);
    expect_val(2, 32'h0400_0000, "R8 expiry");
    expect_val(3, 32'h10, "R8 irq");
    wr(2'd2, 32'h0400_0000);
    expect_val(2, 32'h0, "R3 clear");
    expect_val(3, 32'h0, "R3 irq withdrawn");
    wr(2'd1, 32'h0180_0000);
    ticks(3);
    expect_val(2, 32'h0, "R8 period 8 early");
    ticks(1);
    expect_val(2, 32'h8400_0000, "R8 R9 period 8 and first stage");
    wr(2'd2, 32'hFC00_0000);
    expect_val(2, 32'h0, "R3 clear all");

    // watchdog with chip reset, tb 8..31
    wr(2'd1, 32'h2800_0000);
    ticks(7);
    expect_val(2, 32'h0400_0000, "R9 before stage1");
    expect_val(3, 32'h0, "R8 irq masked");
    ticks(1);
    expect_val(2, 32'h8400_0000, "R9 stage1");
    ticks(8);
    expect_val(2, 32'hC400_0000, "R9 stage2");
    expect_val(3, 32'h08, "R9 irq");
    ticks(7);
    expect_val(3, 32'h08, "R10 no early reset");
    ticks(1);
    expect_val(3, 32'h0A, "R10 chip reset");
    expect_val(2, 32'hE400_0000, "R10 kind copied");
    cyc(1'b0);
    expect_val(3, 32'h08, "R10 single pulse");
    wr(2'd2, 32'hFC00_0000);
    expect_val(2, 32'h0, "R3 clear after reset");

    // interval timer, auto reload (tb 32..)
    wr(2'd1, 32'hC740_0000);
    wr(2'd0, 32'd5);
    expect_val(0, 32'd5, "R4 load");
    ticks(4);
    expect_val(0, 32'd1, "R4 countdown");
    expect_val(2, 32'h0, "R5 not yet");
    ticks(1);
    expect_val(2, 32'h0800_0000, "R5 expiry");
    expect_val(3, 32'h20, "R5 irq");
    expect_val(0, 32'd5, "R6 reload");
    ticks(5);
    expect_val(0, 32'd5, "R6 second reload");
    wr(2'd2, 32'h8000_0000);
    expect_val(2, 32'h0, "R3 bit31 withdraws pit");
    expect_val(3, 32'h0, "R3 pit irq low");

    // one shot
    wr(2'd1, 32'hC700_0000);
    wr(2'd0, 32'd3);
    ticks(3);
    expect_val(2, 32'h0800_0000, "R6 one-shot expiry");
    expect_val(0, 32'd0, "R6 one-shot stops at 0");
    ticks(2);
    expect_val(0, 32'd0, "R6 stays stopped");
    wr(2'd2, 32'h0800_0000);

    // stop conditions
    wr(2'd0, 32'd1);
    ticks(2);
    expect_val(0, 32'd1, "R7 value 1 does not run");
    expect_val(2, 32'h0, "R7 no expiry");
    wr(2'd1, 32'hC300_0000);
    wr(2'd0, 32'd4);
    ticks(2);
    expect_val(0, 32'd4, "R7 enable clear holds");

    // core reset, tb 51..71
    wr(2'd1, 32'h1800_0000);
    ticks(20);
    expect_val(3, 32'h08, "R10 before core reset");
    ticks(1);
    expect_val(3, 32'h0C, "R10 core reset");
    expect_val(2, 32'hD400_0000, "R10 core kind copied");

    done = 1;
    #1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule